// File: doc/BRIEF.md
# Move Command Queue for a Quadrature Channel

This block sits between host writes and one quadrature pulse generator. It holds up to two pending move sizes in a count queue and, beside it, up to two pending control words in a separate queue. A move begins when a count is written. If the channel is idle, that count goes to the generator as soon as it reaches the queue output. If a move is already running, the count waits until the generator reports that its move counter has reached zero, and is then handed over on the next clock edge.

Control words are optional. When a count is handed over and no control word is waiting, the control word used by the previous move goes out again. The host therefore writes a control word before, or in the same cycle as, the count it belongs to. The block reports whether count slots are free, whether a count sits at the queue output, whether the queue is empty, and whether the last move has completed. Two sticky event flags record automatic loads and move completions. Each flag has its own detector enable and interrupt enable, and the enabled flags are ORed into one interrupt request.

Top module: `move_cmd_queue`

## Requirements
- R1: After reset, slotsAvail=1, dataReady=0, queueEmpty=1, moveComplete=1, chanIdle=1, loadStb=0, clOccur=0, mcOccur=0 and irq=0.
- R2: A count written at a clock edge makes queueEmpty low at that edge. dataReady rises at the next edge, when the count reaches the queue output. queueEmpty returns high once the queue holds no count, and dataReady is never high while queueEmpty is high.
- R3: When a count is at the queue output while moveComplete is high, the next edge drives loadStb high for one cycle, with that count on loadCount, and clears moveComplete. For a write into an idle, empty channel, loadStb is high in the second cycle after the write.
- R4: loadCtl carries the control word waiting at the head of the control queue when one is there, and that word is then consumed. With no word waiting, loadCtl repeats the previously used word. The held word is 0 after reset.
- R5: A genZero pulse while a move runs and a count is at the queue output loads that count at the next edge, and moveComplete stays low. At that edge clOccur is set if clDetEn was high.
- R6: A genZero pulse while a move runs and the queue is empty sets moveComplete at the next edge. This rising edge sets mcOccur if mcDetEn was high.
- R7: slotsAvail is low while two counts are held. A count write arriving while slotsAvail is low is dropped and is never loaded.
- R8: chanIdle is high exactly when moveComplete and queueEmpty are both high.
- R9: A qRst pulse empties both queues at the next edge, without a load, and resets the held control word to 0.
- R10: irq = (clOccur & clIntEn) | (mcOccur & mcIntEn). Each flag stays set until its clear input (clOccClr, mcOccClr) is pulsed, and a set in the same cycle takes priority over the clear.
- R11: A genZero pulse while the channel is idle and empty causes no load, leaves moveComplete high and sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| qRst | input | 1 | Synchronous flush of both queues and the held control word |
| cntWrEn | input | 1 | Host writes a move count |
| cntWrData | input | CNT_W (24) | Move size to queue |
| ctlWrEn | input | 1 | Host writes a control word |
| ctlWrData | input | CTL_W (32) | Control word to queue |
| genZero | input | 1 | Generator pulse: its move counter reached zero |
| clDetEn | input | 1 | Count-load event detector enable |
| mcDetEn | input | 1 | Move-complete event detector enable |
| clIntEn | input | 1 | Count-load interrupt enable |
| mcIntEn | input | 1 | Move-complete interrupt enable |
| clOccClr | input | 1 | Clears clOccur |
| mcOccClr | input | 1 | Clears mcOccur |
| loadStb | output | 1 | One-cycle strobe handing a move to the generator |
| loadCount | output | CNT_W (24) | Move size being handed over |
| loadCtl | output | CTL_W (32) | Control word for that move |
| slotsAvail | output | 1 | Count queue has a free slot |
| dataReady | output | 1 | A count sits at the count queue output |
| queueEmpty | output | 1 | No count held in the queue |
| moveComplete | output | 1 | Last move finished and nothing is loaded |
| chanIdle | output | 1 | Channel idle |
| clOccur | output | 1 | Sticky count-load event flag |
| mcOccur | output | 1 | Sticky move-complete event flag |
| irq | output | 1 | Channel interrupt request |

## Verification
The assertions take for granted that genZero reports the end of a move the generator actually started, so a completion can only follow a load. Host writes and qRst are assumed free to arrive in any cycle, including the cycle of a load. The stimulus pulses genZero only after a loadStb has been seen, apart from one deliberate pulse while idle. It writes counts back to back so that the queue reaches the full state and one write lands on a full queue. All inputs change midway between clock edges, so each event falls on a known edge.

// File: rtl/mq_pkg.sv
package mq_pkg;
  localparam int unsigned SLOTS = 2;
  localparam int unsigned FILL_W = $clog2(SLOTS + 1);

  typedef struct packed {
    logic load;
    logic takeCtl;
    logic flush;
  } mqStrobe_t;
endpackage

// File: rtl/mq_fifo2.sv
module mq_fifo2 #(
  parameter int unsigned W = 24
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      flush,
  input  logic                      push,
  input  logic [W-1:0]              pushData,
  input  logic                      pop,
  output logic                      outValid,
  output logic [W-1:0]              outData,
  output logic [mq_pkg::FILL_W-1:0] fill
);
  logic         inV, outV, nInV, nOutV;
  logic [W-1:0] inD, outD, nInD, nOutD;

  always_comb begin
    nInV  = inV;
    nOutV = outV;
    nInD  = inD;
    nOutD = outD;
    if (pop) nOutV = 1'b0;
    if (!nOutV && nInV) begin
      nOutV = 1'b1;
      nOutD = nInD;
      nInV  = 1'b0;
    end
    if (push) begin
      nInV = 1'b1;
      nInD = pushData;
    end
    if (flush) begin
      nInV  = 1'b0;
      nOutV = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inV  <= 1'b0;
      outV <= 1'b0;
      inD  <= '0;
      outD <= '0;
    end else begin
      inV  <= nInV;
      outV <= nOutV;
      inD  <= nInD;
      outD <= nOutD;
    end
  end

  assign outValid = outV;
  assign outData  = outD;
  assign fill     = mq_pkg::FILL_W'(inV) + mq_pkg::FILL_W'(outV);
endmodule

// File: rtl/mq_datapath.sv
module mq_datapath #(
  parameter int unsigned CNT_W = 24,
  parameter int unsigned CTL_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  mq_pkg::mqStrobe_t strb,
  input  logic              cntWrEn,
  input  logic [CNT_W-1:0]  cntWrData,
  input  logic              ctlWrEn,
  input  logic [CTL_W-1:0]  ctlWrData,
  output logic              cntHeadValid,
  output logic              ctlHeadValid,
  output logic              slotsAvail,
  output logic              queueEmpty,
  output logic              loadStb,
  output logic [CNT_W-1:0]  loadCount,
  output logic [CTL_W-1:0]  loadCtl
);
  import mq_pkg::*;
  localparam logic [FILL_W-1:0] FULL_LVL = FILL_W'(SLOTS);

  logic [FILL_W-1:0] cntFill, ctlFill;
  logic [CNT_W-1:0]  cntHead;
  logic [CTL_W-1:0]  ctlHead, heldCtl;
  logic              cntPush, ctlPush;

  assign cntPush = cntWrEn && (cntFill != FULL_LVL) && !strb.flush;
  assign ctlPush = ctlWrEn && (ctlFill != FULL_LVL) && !strb.flush;

  mq_fifo2 #(.W(CNT_W)) i_cntFifo (
    .clk(clk), .rstN(rstN), .flush(strb.flush), .push(cntPush),
    .pushData(cntWrData), .pop(strb.load), .outValid(cntHeadValid),
    .outData(cntHead), .fill(cntFill)
  );

  mq_fifo2 #(.W(CTL_W)) i_ctlFifo (
    .clk(clk), .rstN(rstN), .flush(strb.flush), .push(ctlPush),
    .pushData(ctlWrData), .pop(strb.takeCtl), .outValid(ctlHeadValid),
    .outData(ctlHead), .fill(ctlFill)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldCtl   <= '0;
      loadStb   <= 1'b0;
      loadCount <= '0;
      loadCtl   <= '0;
    end else begin
      loadStb <= strb.load;
      if (strb.flush)        heldCtl <= '0;
      else if (strb.takeCtl) heldCtl <= ctlHead;
      if (strb.load) begin
        loadCount <= cntHead;
        loadCtl   <= strb.takeCtl ? ctlHead : heldCtl;
      end
    end
  end

  assign slotsAvail = (cntFill != FULL_LVL);
  assign queueEmpty = (cntFill == '0);
endmodule

// File: rtl/mq_control.sv
module mq_control (
  input  logic              clk,
  input  logic              rstN,
  input  logic              qRst,
  input  logic              genZero,
  input  logic              cntHeadValid,
  input  logic              ctlHeadValid,
  input  logic              clDetEn,
  input  logic              mcDetEn,
  input  logic              clOccClr,
  input  logic              mcOccClr,
  output mq_pkg::mqStrobe_t strb,
  output logic              moveComplete,
  output logic              clOccur,
  output logic              mcOccur
);
  logic loadNow, autoLoad, mcRise;

  assign loadNow  = cntHeadValid && (moveComplete || genZero) && !qRst;
  assign autoLoad = loadNow && !moveComplete;
  assign mcRise   = genZero && !moveComplete && !loadNow;

  always_comb begin
    strb.load    = loadNow;
    strb.takeCtl = loadNow && ctlHeadValid;
    strb.flush   = qRst;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      moveComplete <= 1'b1;
      clOccur      <= 1'b0;
      mcOccur      <= 1'b0;
    end else begin
      if (loadNow)      moveComplete <= 1'b0;
      else if (genZero) moveComplete <= 1'b1;

      if (autoLoad && clDetEn) clOccur <= 1'b1;
      else if (clOccClr)       clOccur <= 1'b0;

      if (mcRise && mcDetEn) mcOccur <= 1'b1;
      else if (mcOccClr)     mcOccur <= 1'b0;
    end
  end
endmodule

// File: rtl/move_cmd_queue.sv
module move_cmd_queue #(
  parameter int unsigned CNT_W = 24,
  parameter int unsigned CTL_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             qRst,
  input  logic             cntWrEn,
  input  logic [CNT_W-1:0] cntWrData,
  input  logic             ctlWrEn,
  input  logic [CTL_W-1:0] ctlWrData,
  input  logic             genZero,
  input  logic             clDetEn,
  input  logic             mcDetEn,
  input  logic             clIntEn,
  input  logic             mcIntEn,
  input  logic             clOccClr,
  input  logic             mcOccClr,
  output logic             loadStb,
  output logic [CNT_W-1:0] loadCount,
  output logic [CTL_W-1:0] loadCtl,
  output logic             slotsAvail,
  output logic             dataReady,
  output logic             queueEmpty,
  output logic             moveComplete,
  output logic             chanIdle,
  output logic             clOccur,
  output logic             mcOccur,
  output logic             irq
);
  mq_pkg::mqStrobe_t strb;
  logic ctlHeadValid;

  mq_control i_ctrl (
    .clk(clk), .rstN(rstN), .qRst(qRst), .genZero(genZero),
    .cntHeadValid(dataReady), .ctlHeadValid(ctlHeadValid),
    .clDetEn(clDetEn), .mcDetEn(mcDetEn), .clOccClr(clOccClr),
    .mcOccClr(mcOccClr), .strb(strb), .moveComplete(moveComplete),
    .clOccur(clOccur), .mcOccur(mcOccur)
  );

  mq_datapath #(.CNT_W(CNT_W), .CTL_W(CTL_W)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cntWrEn(cntWrEn),
    .cntWrData(cntWrData), .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData),
    .cntHeadValid(dataReady), .ctlHeadValid(ctlHeadValid),
    .slotsAvail(slotsAvail), .queueEmpty(queueEmpty), .loadStb(loadStb),
    .loadCount(loadCount), .loadCtl(loadCtl)
  );

  assign chanIdle = moveComplete && queueEmpty;
  assign irq      = (clOccur && clIntEn) || (mcOccur && mcIntEn);
endmodule

// File: rtl/mq_checker.sv
module mq_checker (
  input logic clk,
  input logic rstN,
  input logic qRst,
  input logic loadStb,
  input logic dataReady,
  input logic queueEmpty,
  input logic slotsAvail,
  input logic moveComplete,
  input logic mcDetEn,
  input logic mcOccur,
  input logic clOccur,
  input logic irq
);
  AST_EMPTY_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    queueEmpty |-> !dataReady); // R2

  AST_LOAD_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rstN)
    loadStb |-> $past(dataReady)); // R3

  AST_LOAD_CLEARS_MC: assert property (@(posedge clk) disable iff (!rstN)
    loadStb |-> !moveComplete); // R3

  AST_MC_RISE_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(moveComplete) && $past(mcDetEn)) |-> mcOccur); // R6

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    !slotsAvail |-> (dataReady && !queueEmpty)); // R7

  AST_QRST_FLUSH: assert property (@(posedge clk) disable iff (!rstN)
    qRst |=> (queueEmpty && !loadStb)); // R9

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (!clOccur && !mcOccur) |-> !irq); // R10

  AST_IDLE_NO_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    ($past(moveComplete) && $past(queueEmpty)) |-> !loadStb); // R11
endmodule

bind move_cmd_queue mq_checker i_mqChk (.*);

// File: tb/test_move_cmd_queue.sv
`timescale 1ns/1ps
module test_move_cmd_queue;
  localparam int CNT_W = 24;
  localparam int CTL_W = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic qRst = 0, cntWrEn = 0, ctlWrEn = 0, genZero = 0;
  logic [CNT_W-1:0] cntWrData = '0;
  logic [CTL_W-1:0] ctlWrData = '0;
  logic clDetEn = 1, mcDetEn = 1, clIntEn = 1, mcIntEn = 1;
  logic clOccClr = 0, mcOccClr = 0;
  logic loadStb, slotsAvail, dataReady, queueEmpty, moveComplete, chanIdle;
  logic clOccur, mcOccur, irq;
  logic [CNT_W-1:0] loadCount;
  logic [CTL_W-1:0] loadCtl;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  move_cmd_queue #(.CNT_W(CNT_W), .CTL_W(CTL_W)) i_move_cmd_queue (.*);

  typedef struct packed {
    logic             hasCtl;
    logic [CTL_W-1:0] ctl;
    logic [CNT_W-1:0] cnt;
    logic [CTL_W-1:0] expCtl;
  } vec_t;

  localparam vec_t VEC [5] = '{
    '{1'b1, 32'h0000_0011, 24'h000005, 32'h0000_0011},
    '{1'b0, 32'h0000_0000, 24'hFFFFFF, 32'h0000_0011},
    '{1'b1, 32'hA5A5_0003, 24'h800000, 32'hA5A5_0003},
    '{1'b0, 32'h0000_0000, 24'h000001, 32'hA5A5_0003},
    '{1'b1, 32'hFFFF_FFFF, 24'h000000, 32'hFFFF_FFFF}
  };

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic pulseZero();
    genZero = 1'b1;
    tick();
    genZero = 1'b0;
  endtask

  task automatic clearFlags();
    clOccClr = 1'b1;
    mcOccClr = 1'b1;
    tick();
    clOccClr = 1'b0;
    mcOccClr = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    tick();
    tick();
    // R1 reset state
    check("R1 slotsAvail", slotsAvail, 1);
    check("R1 dataReady", dataReady, 0);
    check("R1 queueEmpty", queueEmpty, 1);
    check("R1 moveComplete", moveComplete, 1);
    check("R1 chanIdle", chanIdle, 1);
    check("R1 loadStb", loadStb, 0);
    check("R1 irq", irq, 0);
    rstN = 1'b1;
    tick();

    // Table walk: idle loads, control reuse, completion
    for (int i = 0; i < 5; i++) begin
      cntWrData = VEC[i].cnt;
      cntWrEn   = 1'b1;
      ctlWrEn   = VEC[i].hasCtl;
      ctlWrData = VEC[i].ctl;
      tick();
      cntWrEn = 1'b0;
      ctlWrEn = 1'b0;
      check("R2 queueEmpty low", queueEmpty, 0);
      check("R2 dataReady not yet", dataReady, 0);
      check("R8 chanIdle busy", chanIdle, 0);
      tick();
      check("R2 dataReady", dataReady, 1);
      check("R3 no early load", loadStb, 0);
      tick();
      check("R3 loadStb", loadStb, 1);
      check("R3 loadCount", loadCount, 32'(VEC[i].cnt));
      check("R4 loadCtl", loadCtl, VEC[i].expCtl);
      check("R3 moveComplete cleared", moveComplete, 0);
      check("R2 queueEmpty again", queueEmpty, 1);
      tick();
      check("R3 single strobe", loadStb, 0);
      pulseZero();
      check("R6 moveComplete set", moveComplete, 1);
      check("R6 mcOccur", mcOccur, 1);
      check("R8 chanIdle", chanIdle, 1);
      check("R10 irq from mc", irq, 1);
      clearFlags();
      check("R10 mcOccur cleared", mcOccur, 0);
      check("R10 irq cleared", irq, 0);
    end

    // R11 genZero while idle
    pulseZero();
    check("R11 no load", loadStb, 0);
    check("R11 moveComplete", moveComplete, 1);
    check("R11 no mc flag", mcOccur, 0);
    check("R11 no cl flag", clOccur, 0);

    // R5 / R7: three back-to-back writes, third lands on a full queue
    cntWrEn = 1'b1; cntWrData = 24'h00000A;
    tick();
    cntWrData = 24'h00000B;
    tick();
    check("R7 full", slotsAvail, 0);
    cntWrData = 24'h00000C;
    tick();
    cntWrEn = 1'b0;
    check("R3 first loaded", loadCount, 32'h0A);
    check("R3 first strobe", loadStb, 1);
    check("R7 slot freed", slotsAvail, 1);
    tick();
    check("R2 second at head", dataReady, 1);
    pulseZero();
    check("R5 auto load", loadStb, 1);
    check("R5 auto count", loadCount, 32'h0B);
    check("R5 clOccur", clOccur, 1);
    check("R5 stays busy", moveComplete, 0);
    check("R10 irq from cl", irq, 1);
    check("R7 dropped write", queueEmpty, 1);
    tick();
    pulseZero();
    check("R7 nothing loaded", loadStb, 0);
    check("R6 complete after drop", moveComplete, 1);
    clearFlags();

    // R5 / R6 with detectors disabled
    clDetEn = 1'b0; mcDetEn = 1'b0;
    cntWrEn = 1'b1; cntWrData = 24'h000100;
    tick();
    cntWrData = 24'h000200;
    tick();
    cntWrEn = 1'b0;
    tick();
    pulseZero();
    check("R5 load w/o detector", loadCount, 32'h200);
    check("R5 clOccur held low", clOccur, 0);
    tick();
    pulseZero();
    check("R6 complete w/o detector", moveComplete, 1);
    check("R6 mcOccur held low", mcOccur, 0);

    // R10 interrupt mask and set priority over clear
    mcDetEn = 1'b1; mcIntEn = 1'b0;
    cntWrEn = 1'b1; cntWrData = 24'h000033;
    tick();
    cntWrEn = 1'b0;
    tick();
    tick();
    mcOccClr = 1'b1;
    pulseZero();
    mcOccClr = 1'b0;
    check("R10 set beats clear", mcOccur, 1);
    check("R10 masked irq", irq, 0);
    mcIntEn = 1'b1;
    #1;
    check("R10 unmasked irq", irq, 1);
    clearFlags();

    // R9 queue reset
    cntWrEn = 1'b1; cntWrData = 24'h000044;
    ctlWrEn = 1'b1; ctlWrData = 32'h0000_0077;
    tick();
    cntWrEn = 1'b0; ctlWrEn = 1'b0;
    tick();
    tick();
    check("R4 new ctl", loadCtl, 32'h77);
    cntWrEn = 1'b1; cntWrData = 24'h000055;
    tick();
    cntWrEn = 1'b0;
    tick();
    check("R9 queued before flush", dataReady, 1);
    qRst = 1'b1;
    tick();
    qRst = 1'b0;
    check("R9 queue emptied", queueEmpty, 1);
    check("R9 head cleared", dataReady, 0);
    check("R9 no load", loadStb, 0);
    pulseZero();
    check("R9 no load after flush", loadStb, 0);
    check("R9 complete", moveComplete, 1);
    cntWrEn = 1'b1; cntWrData = 24'h000066;
    tick();
    cntWrEn = 1'b0;
    tick();
    tick();
    check("R9 load after flush", loadCount, 32'h66);
    check("R9 held ctl reset", loadCtl, 32'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule